// File: doc/BRIEF.md
# Multi-Channel Cycle Counter Timer

The block holds a free-running cycle counter, 55 bits wide, that advances by one on every clock. Three compare channels watch it. A channel latches a pending event the first time the counter reaches or passes its compare value. If its enable bit is set, it then raises a level interrupt. That interrupt carries a vector index and a destination processor id, both taken from the channel's configuration register.

Software works through a flat word-addressed register port: a write strobe, an address, write data, and combinational read data. The pending flags of all channels share one status word. A separate clear address removes flags by writing ones to their bit positions.

The safe arming sequence has three steps. First park the compare at all ones. Then clear the pending flag. Then write the real expiry. Any compare write re-arms the channel. If the counter already stands at or beyond the new value, the pending flag comes up at once, so a late expiry is never lost.

Top module: `cyc_cmp_timer`

## Requirements
- R1: The counter at word address 0 resets to 0 and adds 1 on every clock, wrapping at 55 bits. Reads return it zero-extended, so bits 63:55 read 0. Writes to address 0 are ignored.
- R2: Channel n's compare register sits at address 4+4n and holds 55 bits, read back zero-extended. It resets to all ones.
- R3: Channel n's pending flag sets on the clock edge that ends the first cycle in which the counter is at least the compare value. The flag stays set until cleared. It does not set again while the counter stays at or above the same compare value.
- R4: A compare write re-arms the channel. If the counter is already at or above the new value, the pending flag is set by the second clock edge after the write edge, and a read of status then shows 1.
- R5: A compare value of all ones never produces a match while the counter is below all ones.
- R6: The status word at address 1 holds channel n's pending flag in bit n, with all other bits 0. Writes to address 1 are ignored.
- R7: A write to address 2 clears each pending flag whose bit is 1 in the write data. Flags whose bits are 0 are left unchanged. Reads of address 2 return the status word.
- R8: When a clear and a new match for the same channel fall in the same cycle, the match wins and the flag stays set.
- R9: Channel n's enable sits at address 5+4n, bit 0. It resets to 0, and its other bits read 0.
- R10: irq[n] is a level that is high exactly when channel n's pending flag and enable bit are both 1.
- R11: Channel n's configuration at address 6+4n holds a vector index in bits 7:0 and a destination id in bits 31:16. Its other bits read 0 and it resets to 0. The two fields drive irq_vec[8n+7:8n] and irq_dest[16n+15:16n] at all times.
- R12: Every address that is not mapped above reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| irq | output | 3 | Per-channel interrupt level |
| irq_vec | output | 24 | Vector index per channel, 8 bits each |
| irq_dest | output | 48 | Destination id per channel, 16 bits each |

## Verification
Two functions can meet on one channel's pending flag in the same cycle: a new match that wants to set it, and a write to the clear alias that wants to remove it. The bench provokes this directly. It loads a compare value a known number of cycles ahead of the counter and times the clear write to land exactly on the matching cycle. It then expects the flag to read 1 on the next status read.

Random traffic adds more collisions. It mixes clear writes with compare writes placed a few cycles around the counter, and a cycle-accurate bench model judges every read and every interrupt output.

// File: rtl/cct_pkg.sv
package cct_pkg;

  // word addresses of the shared registers
  localparam int ADDR_COUNT = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_CLEAR = 2;
  // per-channel block: base + stride*n
  localparam int CH_BASE    = 4;
  localparam int CH_STRIDE  = 4;

  typedef enum logic [1:0] {
    FLD_CMP  = 2'd0,
    FLD_EN   = 2'd1,
    FLD_CFG  = 2'd2,
    FLD_NONE = 2'd3
  } ch_field_e;

  function automatic int chan_index(input int a);
    if (a < CH_BASE) return 0;
    return (a - CH_BASE) / CH_STRIDE;
  endfunction

  function automatic ch_field_e chan_field(input int a);
    if (a < CH_BASE) return FLD_NONE;
    case ((a - CH_BASE) % CH_STRIDE)
      0:       return FLD_CMP;
      1:       return FLD_EN;
      2:       return FLD_CFG;
      default: return FLD_NONE;
    endcase
  endfunction

  // match rule: counter has reached or passed the compare value
  function automatic logic reached(input logic [63:0] cnt, input logic [63:0] cmp);
    return cnt >= cmp;
  endfunction

endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + STEP;
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cct_pkg::*;
#(
  parameter int CNT_W     = 55,
  parameter int VEC_W     = 8,
  parameter int PID_W     = 16,
  parameter int PID_SHIFT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wr_cmp,
  input  logic             wr_en,
  input  logic             wr_cfg,
  input  logic             clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cmp_q,
  output logic             en_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [PID_W-1:0] pid_q,
  output logic             hit,
  output logic             pend_q
);
  logic ge;
  logic ge_q;

  assign ge  = reached(64'(cnt), 64'(cmp_q));
  assign hit = ge & ~ge_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      en_q   <= 1'b0;
      vec_q  <= '0;
      pid_q  <= '0;
      ge_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // a compare write re-arms the edge detector
      ge_q <= wr_cmp ? 1'b0 : ge;
      if (wr_cmp) cmp_q <= wdata;
      if (wr_en)  en_q  <= wdata[0];
      if (wr_cfg) begin
        vec_q <= wdata[VEC_W-1:0];
        pid_q <= wdata[PID_SHIFT +: PID_W];
      end
      // set has priority over clear
      if (hit)      pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cct_regif.sv
module cct_regif
  import cct_pkg::*;
#(
  parameter int CNT_W     = 55,
  parameter int NCH       = 3,
  parameter int DW        = 64,
  parameter int AW        = 5,
  parameter int VEC_W     = 8,
  parameter int PID_W     = 16,
  parameter int PID_SHIFT = 16
) (
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [NCH-1:0]       wmask,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NCH-1:0]       pend,
  input  logic [NCH*CNT_W-1:0] cmp_flat,
  input  logic [NCH-1:0]       en,
  input  logic [NCH*VEC_W-1:0] vec_flat,
  input  logic [NCH*PID_W-1:0] pid_flat,
  output logic [NCH-1:0]       wr_cmp,
  output logic [NCH-1:0]       wr_en,
  output logic [NCH-1:0]       wr_cfg,
  output logic                 clr_wr,
  output logic [NCH-1:0]       clr_mask,
  output logic [DW-1:0]        rdata
);
  int        a_int;
  int        rd_ch;
  ch_field_e rd_fld;

  assign a_int  = 32'(addr);
  assign rd_ch  = chan_index(a_int);
  assign rd_fld = chan_field(a_int);
  assign clr_wr = we && (a_int == ADDR_CLEAR);

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    logic sel;
    assign sel         = we && (rd_ch == g);
    assign wr_cmp[g]   = sel && (rd_fld == FLD_CMP);
    assign wr_en[g]    = sel && (rd_fld == FLD_EN);
    assign wr_cfg[g]   = sel && (rd_fld == FLD_CFG);
    assign clr_mask[g] = clr_wr && wmask[g];
  end

  always_comb begin
    rdata = '0;
    if (a_int == ADDR_COUNT) begin
      rdata[CNT_W-1:0] = cnt;
    end else if (a_int == ADDR_STAT || a_int == ADDR_CLEAR) begin
      rdata[NCH-1:0] = pend;
    end else if (rd_ch < NCH) begin
      case (rd_fld)
        FLD_CMP: rdata[CNT_W-1:0] = cmp_flat[rd_ch*CNT_W +: CNT_W];
        FLD_EN:  rdata[0]         = en[rd_ch];
        FLD_CFG: begin
          rdata[VEC_W-1:0]           = vec_flat[rd_ch*VEC_W +: VEC_W];
          rdata[PID_SHIFT +: PID_W]  = pid_flat[rd_ch*PID_W +: PID_W];
        end
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer #(
  parameter int CNT_W     = 55,
  parameter int NCH       = 3,
  parameter int DW        = 64,
  parameter int AW        = 5,
  parameter int VEC_W     = 8,
  parameter int PID_W     = 16,
  parameter int PID_SHIFT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [NCH-1:0]       irq,
  output logic [NCH*VEC_W-1:0] irq_vec,
  output logic [NCH*PID_W-1:0] irq_dest
);
  logic [CNT_W-1:0]     cnt_q;
  logic [NCH*CNT_W-1:0] cmp_flat;
  logic [NCH-1:0]       en_w;
  logic [NCH-1:0]       pend_w;
  logic [NCH-1:0]       hit_w;
  logic [NCH-1:0]       wr_cmp_w;
  logic [NCH-1:0]       wr_en_w;
  logic [NCH-1:0]       wr_cfg_w;
  logic [NCH-1:0]       clr_mask_w;
  logic                 clr_wr_w;
  logic                 wdata_unused;

  assign wdata_unused = ^reg_wdata[DW-1:CNT_W];

  cct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt_q)
  );

  cct_regif #(
    .CNT_W(CNT_W), .NCH(NCH), .DW(DW), .AW(AW),
    .VEC_W(VEC_W), .PID_W(PID_W), .PID_SHIFT(PID_SHIFT)
  ) u_regif (
    .we       (reg_we),
    .addr     (reg_addr),
    .wmask    (reg_wdata[NCH-1:0]),
    .cnt      (cnt_q),
    .pend     (pend_w),
    .cmp_flat (cmp_flat),
    .en       (en_w),
    .vec_flat (irq_vec),
    .pid_flat (irq_dest),
    .wr_cmp   (wr_cmp_w),
    .wr_en    (wr_en_w),
    .wr_cfg   (wr_cfg_w),
    .clr_wr   (clr_wr_w),
    .clr_mask (clr_mask_w),
    .rdata    (reg_rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cct_channel #(
      .CNT_W(CNT_W), .VEC_W(VEC_W), .PID_W(PID_W), .PID_SHIFT(PID_SHIFT)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt_q),
      .wr_cmp (wr_cmp_w[g]),
      .wr_en  (wr_en_w[g]),
      .wr_cfg (wr_cfg_w[g]),
      .clr    (clr_mask_w[g]),
      .wdata  (reg_wdata[CNT_W-1:0]),
      .cmp_q  (cmp_flat[g*CNT_W +: CNT_W]),
      .en_q   (en_w[g]),
      .vec_q  (irq_vec[g*VEC_W +: VEC_W]),
      .pid_q  (irq_dest[g*PID_W +: PID_W]),
      .hit    (hit_w[g]),
      .pend_q (pend_w[g])
    );
    assign irq[g] = pend_w[g] & en_w[g];
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 55,
  parameter int NCH   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CNT_W-1:0]     cnt,
  input logic [NCH*CNT_W-1:0] cmp_flat,
  input logic [NCH-1:0]       hit,
  input logic [NCH-1:0]       pend,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       irq,
  input logic [NCH-1:0]       wr_cmp,
  input logic                 clr_wr,
  input logic [NCH-1:0]       wmask
);
  localparam logic [CNT_W-1:0] ONES = '1;
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_pend_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(pend[i]) && pend[i]) |-> $past(hit[i]));

    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(pend[i]) && !$past(clr_wr && wmask[i])) |-> pend[i]);

    assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(wr_cmp[i]) && (cnt >= cmp_flat[i*CNT_W +: CNT_W])) |-> hit[i]);

    assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_flat[i*CNT_W +: CNT_W] == ONES && cnt != ONES) |-> !hit[i]);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_wr && wmask[i] && !hit[i])) |-> !pend[i]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(hit[i])) |-> pend[i]);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(irq[i])) |-> ($rose(pend[i]) || $rose(en[i])));
  end
endmodule

bind cyc_cmp_timer cct_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt_q),
  .cmp_flat (cmp_flat),
  .hit      (hit_w),
  .pend     (pend_w),
  .en       (en_w),
  .irq      (irq),
  .wr_cmp   (wr_cmp_w),
  .clr_wr   (clr_wr_w),
  .wmask    (reg_wdata[NCH-1:0])
);

// File: tb/cyc_cmp_timer_test.sv
`timescale 1ns/1ps
module cyc_cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic [2:0]  irq;
  logic [23:0] irq_vec;
  logic [47:0] irq_dest;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [63:0] last_rd;

  // bench model state
  logic [54:0] m_cnt;
  logic [54:0] m_cmp [3];
  logic        m_en  [3];
  logic [7:0]  m_vec [3];
  logic [15:0] m_pid [3];
  logic        m_geq [3];
  logic [2:0]  m_pend;

  cyc_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .irq_vec(irq_vec), .irq_dest(irq_dest)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      m_pend <= '0;
      for (int c = 0; c < 3; c++) begin
        m_cmp[c] <= '1; m_en[c] <= 1'b0; m_vec[c] <= '0;
        m_pid[c] <= '0; m_geq[c] <= 1'b0;
      end
    end else begin
      m_cnt <= m_cnt + 55'd1;
      for (int c = 0; c < 3; c++) begin
        if (reg_we && reg_addr == 5'(4 + 4*c)) begin
          m_cmp[c] <= reg_wdata[54:0];
          m_geq[c] <= 1'b0;
        end else begin
          m_geq[c] <= (m_cnt >= m_cmp[c]);
        end
        if (reg_we && reg_addr == 5'(5 + 4*c)) m_en[c] <= reg_wdata[0];
        if (reg_we && reg_addr == 5'(6 + 4*c)) begin
          m_vec[c] <= reg_wdata[7:0];
          m_pid[c] <= reg_wdata[31:16];
        end
        if ((m_cnt >= m_cmp[c]) && !m_geq[c]) m_pend[c] <= 1'b1;
        else if (reg_we && reg_addr == 5'd2 && reg_wdata[c]) m_pend[c] <= 1'b0;
      end
    end
  end

  function automatic logic [63:0] exp_read(input logic [4:0] a);
    int ai;
    int c;
    int f;
    ai = int'(a);
    if (ai == 0) return {9'b0, m_cnt};
    if (ai == 1 || ai == 2) return {61'b0, m_pend};
    if (ai < 4 || ai >= 16) return 64'b0;
    c = (ai - 4) / 4;
    f = (ai - 4) % 4;
    case (f)
      0: return {9'b0, m_cmp[c]};
      1: return {63'b0, m_en[c]};
      2: return {32'b0, m_pid[c], 8'b0, m_vec[c]};
      default: return 64'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    int ai;
    ai = int'(a);
    if (ai == 0) return "R1";
    if (ai == 1) return "R6";
    if (ai == 2) return "R7";
    if (ai < 4 || ai >= 16) return "R12";
    case ((ai - 4) % 4)
      0: return "R2";
      1: return "R9";
      2: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: outputs checked, inputs driven at the falling edge
  task automatic do_cycle(input logic we, input logic [4:0] a,
                          input logic [63:0] d, input logic rel);
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      chk("R10", 64'(irq[c]), 64'(m_pend[c] & m_en[c]));
      chk("R11", 64'(irq_vec[c*8 +: 8]), 64'(m_vec[c]));
      chk("R11", 64'(irq_dest[c*16 +: 16]), 64'(m_pid[c]));
    end
    reg_we    = we;
    reg_addr  = a;
    reg_wdata = rel ? 64'(m_cnt + d[54:0]) : d;
    #1;
    last_rd = reg_rdata;
    if (!we) chk(tag_of(a), reg_rdata, exp_read(a));
  endtask

  task automatic idle(input logic [4:0] a, input int n);
    for (int k = 0; k < n; k++) do_cycle(1'b0, a, 64'd0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [63:0] v1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    #1;
    // reset state, read with reset held
    reg_addr = 5'd0;  #1; chk("R1 reset", reg_rdata, 64'd0);
    reg_addr = 5'd4;  #1; chk("R2 reset", reg_rdata, 64'h007F_FFFF_FFFF_FFFF);
    reg_addr = 5'd1;  #1; chk("R6 reset", reg_rdata, 64'd0);
    reg_addr = 5'd13; #1; chk("R9 reset", reg_rdata, 64'd0);
    reg_addr = 5'd14; #1; chk("R11 reset", reg_rdata, 64'd0);
    chk("R10 reset", 64'(irq), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: counter steps by one, upper bits zero, writes ignored
    idle(5'd0, 2);
    v1 = last_rd;
    idle(5'd0, 1);
    chk("R1 step", last_rd, v1 + 64'd1);
    do_cycle(1'b1, 5'd0, 64'hFFFF_0000_1234_5678, 1'b0);
    idle(5'd0, 1);
    chk("R1 write ignored", last_rd, v1 + 64'd3);
    do_cycle(1'b1, 5'd1, 64'h7, 1'b0);
    idle(5'd1, 1);
    chk("R6 write ignored", last_rd, 64'd0);

    // R4: compare already passed -> pending visible two edges later
    do_cycle(1'b1, 5'd4, 64'(-3), 1'b1);
    idle(5'd1, 2);
    chk("R4 missed expiry", last_rd & 64'h1, 64'h1);

    // R3: clear while counter remains above compare -> no re-set
    do_cycle(1'b1, 5'd2, 64'h1, 1'b0);
    idle(5'd1, 6);
    chk("R3 no re-set", last_rd & 64'h1, 64'h0);

    // R3: future match on channel 1
    do_cycle(1'b1, 5'd8, 64'd10, 1'b1);
    idle(5'd1, 5);
    chk("R3 not yet", last_rd & 64'h2, 64'h0);
    idle(5'd1, 10);
    chk("R3 matched", last_rd & 64'h2, 64'h2);

    // R10: enable gates the interrupt level
    do_cycle(1'b1, 5'd9, 64'h1, 1'b0);
    idle(5'd9, 1);
    chk("R10 on", 64'(irq), 64'h2);
    do_cycle(1'b1, 5'd9, 64'h0, 1'b0);
    idle(5'd9, 1);
    chk("R10 off", 64'(irq), 64'h0);

    // R5: channel 2 parked at all ones stays quiet
    do_cycle(1'b1, 5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    idle(5'd1, 30);
    chk("R5 parked", last_rd & 64'h4, 64'h0);

    // R7: clear only the flags written as one
    do_cycle(1'b1, 5'd4, 64'(-1), 1'b1);
    idle(5'd1, 2);
    chk("R7 both set", last_rd & 64'h3, 64'h3);
    do_cycle(1'b1, 5'd2, 64'h2, 1'b0);
    idle(5'd2, 1);
    chk("R7 partial clear", last_rd & 64'h3, 64'h1);

    // R8: clear lands exactly on the matching cycle
    do_cycle(1'b1, 5'd2, 64'h1, 1'b0);
    do_cycle(1'b1, 5'd4, 64'd5, 1'b1);
    idle(5'd1, 4);
    chk("R8 before", last_rd & 64'h1, 64'h0);
    do_cycle(1'b1, 5'd2, 64'h1, 1'b0);
    idle(5'd1, 1);
    chk("R8 set wins", last_rd & 64'h1, 64'h1);

    // R11: field placement and readback masking
    do_cycle(1'b1, 5'd14, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    idle(5'd14, 1);
    chk("R11 readback", last_rd, 64'h0000_0000_FFFF_00FF);
    chk("R11 vec out", 64'(irq_vec[23:16]), 64'hFF);
    chk("R11 dest out", 64'(irq_dest[47:32]), 64'hFFFF);

    // R12: unmapped addresses
    idle(5'd3, 1);  chk("R12 addr3", last_rd, 64'd0);
    idle(5'd7, 1);  chk("R12 addr7", last_rd, 64'd0);
    idle(5'd31, 1); chk("R12 addr31", last_rd, 64'd0);

    // random traffic against the bench model
    for (int k = 0; k < 3000; k++) begin
      logic [4:0]  a;
      logic [63:0] d;
      logic        we;
      logic        rel;
      a   = ($urandom_range(0, 19) == 0) ? 5'd31 : 5'(int'($urandom_range(0, 15)));
      we  = 1'($urandom_range(0, 1));
      rel = 1'b0;
      if (a >= 5'd4 && a < 5'd16 && a[1:0] == 2'd0) begin
        rel = 1'b1;
        d   = 64'($urandom_range(0, 90)) - 64'd30;
      end else if (a == 5'd2) begin
        d = 64'($urandom_range(0, 7));
      end else begin
        d = {$urandom, $urandom};
      end
      do_cycle(we, a, d, rel);
    end
    idle(5'd1, 2);
    finish_run();
  end
endmodule